// File: doc/BRIEF.md
# Power-Management Event Window and SCI Generator

This block gives a host a small I/O window for power-management events. The window holds four registers: an event status register, an event enable register, a control register and a free-running timer. Configuration-space inputs set where the window sits in a 16-bit I/O space and whether it is active. Three external event lines (power button, RTC alarm, global-lock release) and the timer's top-bit transitions latch status bits. A level interrupt line, `sci`, stays high while any of the four interrupt sources has both its status and its enable bit set.

Software enables the sources it wants. It services an interrupt by reading the status register and writing ones back to clear the bits it has handled. The timer advances on a tick-enable input. Its count can be read at any time and cannot be written.

Top module: `pm_event_ctrl`

## Requirements
- R1: After reset, status, enable, control and timer all read zero and `sci` is low.
- R2: The window base is `cfg_base[15:6]` followed by six zero bits. Bits 31:16 and 5:0 of `cfg_base` are ignored. An access claims the window (`io_hit` = 1) only when `cfg_win_en` = 1, `io_rd` or `io_wr` is high, and `io_addr` lies within base..base+63.
- R3: Window offsets are: 0x00 status, 0x02 enable (16 bits, read/write), 0x04 control (16 bits, read/write), 0x08 timer (zero-extended to 32 bits, read-only). Any other offset reads zero and ignores writes. `io_rdata` is zero unless a read claims the window. Reads and `io_hit` are combinational.
- R4: Status bits exist only at bit 0 (timer), bit 5 (global lock), bit 8 (power button) and bit 10 (RTC); all other bits read zero. Writing 1 to an existing status bit clears it, and writing 0 leaves it unchanged.
- R5: A rising edge on `evt_pwrbtn`, `evt_rtc` or `evt_gbl` sets status bit 8, 10 or 5 at the next clock edge. A level that stays high does not set the bit again after it has been cleared.
- R6: `sci` equals the OR over bits 0, 5, 8 and 10 of (status AND enable). Other enable bits and the control register have no effect on `sci`.
- R7: The timer (TMR_W bits, default 24) increases by one on each clock edge where `tick` = 1 and holds otherwise. Writes at offset 0x08 do not change it.
- R8: Each change of the timer's top bit, in either direction, sets status bit 0, but only while enable bit 0 is 1. With enable bit 0 = 0, the transition is lost.
- R9: Writes that do not claim the window, whether outside it or while it is disabled, change no register.
- R10: When an event rising edge and a write-1-to-clear of the same status bit fall on the same clock edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | 32 | Configuration dword supplying the window base |
| cfg_win_en | input | 1 | Window enable from configuration space |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 32 | Read data, zero when not claimed |
| io_hit | output | 1 | Access falls inside the enabled window |
| tick | input | 1 | Timer advance enable |
| evt_pwrbtn | input | 1 | Power-button event line |
| evt_rtc | input | 1 | RTC alarm event line |
| evt_gbl | input | 1 | Global-lock release event line |
| sci | output | 1 | Level interrupt |

## Verification
The hardest state to reach from the ports is the timer top-bit transition. At the default width it takes millions of ticks, so the bench instantiates the block with a 10-bit timer. It first reads the count, then drives exactly the number of ticks needed to land one short of the transition, and then drives one more. This checks status bit 0 at both the rising and the falling top-bit transition, and again with the enable bit off. The collision between an event edge and a clearing write is reached by driving both on the same clock edge.

// File: rtl/pmev_pkg.sv
package pmev_pkg;
   localparam int PM_REG_W = 16;
   localparam int BIT_TMR  = 0;
   localparam int BIT_GBL  = 5;
   localparam int BIT_PWR  = 8;
   localparam int BIT_RTC  = 10;
   localparam logic [PM_REG_W-1:0] STS_IMPL =
      PM_REG_W'((1 << BIT_TMR) | (1 << BIT_GBL) | (1 << BIT_PWR) | (1 << BIT_RTC));
   localparam logic [PM_REG_W-1:0] SCI_SRC = STS_IMPL;
   localparam int NUM_EVT = 3;
   localparam int EVT_BITS [NUM_EVT] = '{BIT_PWR, BIT_RTC, BIT_GBL};
   localparam int OFF_STS = 'h00;
   localparam int OFF_EN  = 'h02;
   localparam int OFF_CTL = 'h04;
   localparam int OFF_TMR = 'h08;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_STS,
      SEL_EN,
      SEL_CTL,
      SEL_TMR
   } pm_sel_e;
endpackage

// File: rtl/pmev_decode.sv
module pmev_decode
   import pmev_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int CFG_W     = 32,
   parameter int WIN_BYTES = 64
) (
   input  logic [CFG_W-1:0]  cfg_base,
   input  logic              cfg_win_en,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_rd,
   input  logic              io_wr,
   output logic              hit,
   output pm_sel_e           sel
);
   localparam int OFF_W = $clog2(WIN_BYTES);

   initial begin
      assert (WIN_BYTES >= 16 && (WIN_BYTES & (WIN_BYTES - 1)) == 0)
         else $fatal(1, "WIN_BYTES must be a power of two, at least 16");
      assert (ADDR_W > OFF_W && ADDR_W < CFG_W)
         else $fatal(1, "ADDR_W must exceed the offset width and fit below CFG_W");
   end

   logic [OFF_W-1:0] off;
   logic             base_match;
   logic             unused_cfg;

   assign unused_cfg = ^{cfg_base[CFG_W-1:ADDR_W], cfg_base[OFF_W-1:0]};
   assign base_match = (io_addr[ADDR_W-1:OFF_W] == cfg_base[ADDR_W-1:OFF_W]);
   assign off        = io_addr[OFF_W-1:0];
   assign hit        = cfg_win_en & (io_rd | io_wr) & base_match;

   always_comb begin
      sel = SEL_NONE;
      if (off == OFF_W'(OFF_STS))      sel = SEL_STS;
      else if (off == OFF_W'(OFF_EN))  sel = SEL_EN;
      else if (off == OFF_W'(OFF_CTL)) sel = SEL_CTL;
      else if (off == OFF_W'(OFF_TMR)) sel = SEL_TMR;
   end
endmodule

// File: rtl/pmev_timer.sv
module pmev_timer #(
   parameter int TMR_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   output logic [TMR_W-1:0] cnt,
   output logic             msb_flip
);
   initial begin
      assert (TMR_W >= 2 && TMR_W <= 32)
         else $fatal(1, "TMR_W must be between 2 and 32");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
   end

   // top bit changes exactly when every lower bit is one and the counter advances
   assign msb_flip = tick & (&cnt[TMR_W-2:0]);

   assert_tmr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> cnt == $past(cnt) + 1'b1);
   assert_tmr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));
endmodule

// File: rtl/pmev_regs.sv
module pmev_regs
   import pmev_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  pm_sel_e             sel,
   input  logic [PM_REG_W-1:0] wdata,
   input  logic [NUM_EVT-1:0]  evt_in,
   input  logic                tmr_flip,
   output logic [PM_REG_W-1:0] sts_q,
   output logic [PM_REG_W-1:0] en_q,
   output logic [PM_REG_W-1:0] ctl_q,
   output logic                sci
);
   logic [NUM_EVT-1:0]  rise;
   logic [PM_REG_W-1:0] set_vec;
   logic [PM_REG_W-1:0] clr_vec;

   for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= evt_in[i];
      end
      assign rise[i] = evt_in[i] & ~prev_q;
   end

   always_comb begin
      set_vec = '0;
      for (int i = 0; i < NUM_EVT; i++) begin
         if (rise[i]) set_vec[EVT_BITS[i]] = 1'b1;
      end
      // overflow detection armed only while enabled and not already pending
      set_vec[BIT_TMR] = tmr_flip & en_q[BIT_TMR] & ~sts_q[BIT_TMR];
   end

   assign clr_vec = (wr_en && sel == SEL_STS) ? (wdata & STS_IMPL) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q <= '0;
         en_q  <= '0;
         ctl_q <= '0;
      end else begin
         sts_q <= ((sts_q & ~clr_vec) | set_vec) & STS_IMPL;
         if (wr_en && sel == SEL_EN)  en_q  <= wdata;
         if (wr_en && sel == SEL_CTL) ctl_q <= wdata;
      end
   end

   assign sci = |(sts_q & en_q & SCI_SRC);

   assert_pwr_edge_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt_in[0]) |=> sts_q[BIT_PWR]);
   assert_rtc_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[BIT_RTC] && !rise[1]) |=> !sts_q[BIT_RTC]);
   assert_sci_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_q & SCI_SRC) == '0) |-> !sci);
   assert_tmr_disarmed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_flip && !en_q[BIT_TMR] && !sts_q[BIT_TMR]) |=> !sts_q[BIT_TMR]);
endmodule

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl
   import pmev_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int CFG_W     = 32,
   parameter int DATA_W    = 32,
   parameter int WIN_BYTES = 64,
   parameter int TMR_W     = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CFG_W-1:0]    cfg_base,
   input  logic                cfg_win_en,
   input  logic [ADDR_W-1:0]   io_addr,
   input  logic                io_wr,
   input  logic                io_rd,
   input  logic [PM_REG_W-1:0] io_wdata,
   output logic [DATA_W-1:0]   io_rdata,
   output logic                io_hit,
   input  logic                tick,
   input  logic                evt_pwrbtn,
   input  logic                evt_rtc,
   input  logic                evt_gbl,
   output logic                sci
);
   initial begin
      assert (DATA_W >= TMR_W && DATA_W >= PM_REG_W)
         else $fatal(1, "DATA_W must hold the timer and the 16-bit registers");
   end

   pm_sel_e             sel;
   logic [PM_REG_W-1:0] sts_q, en_q, ctl_q;
   logic [TMR_W-1:0]    tmr_cnt;
   logic                tmr_flip;

   pmev_decode #(.ADDR_W(ADDR_W), .CFG_W(CFG_W), .WIN_BYTES(WIN_BYTES)) u_dec (
      .cfg_base(cfg_base), .cfg_win_en(cfg_win_en), .io_addr(io_addr),
      .io_rd(io_rd), .io_wr(io_wr), .hit(io_hit), .sel(sel)
   );

   pmev_timer #(.TMR_W(TMR_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(tmr_cnt), .msb_flip(tmr_flip)
   );

   pmev_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(io_hit & io_wr), .sel(sel), .wdata(io_wdata),
      .evt_in({evt_gbl, evt_rtc, evt_pwrbtn}), .tmr_flip(tmr_flip),
      .sts_q(sts_q), .en_q(en_q), .ctl_q(ctl_q), .sci(sci)
   );

   always_comb begin
      io_rdata = '0;
      if (io_hit && io_rd) begin
         unique case (sel)
            SEL_STS: io_rdata = DATA_W'(sts_q);
            SEL_EN:  io_rdata = DATA_W'(en_q);
            SEL_CTL: io_rdata = DATA_W'(ctl_q);
            SEL_TMR: io_rdata = DATA_W'(tmr_cnt);
            default: io_rdata = '0;
         endcase
      end
   end

   assert_no_hit_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_win_en |-> !io_hit);
   assert_outside_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !io_hit |=> ($stable(en_q) && $stable(ctl_q)));
endmodule

// File: tb/tb_pm_event_ctrl.sv
module tb_pm_event_ctrl;
   localparam int TW = 10;
   localparam logic [15:0] BASE = 16'hB000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cfg_base = 32'hABCD_B02A;
   logic        cfg_win_en = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0, io_rd = 1'b0;
   logic [15:0] io_wdata = '0;
   logic [31:0] io_rdata;
   logic        io_hit;
   logic        tick = 1'b0;
   logic        evt_pwrbtn = 1'b0, evt_rtc = 1'b0, evt_gbl = 1'b0;
   logic        sci;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pm_event_ctrl #(.TMR_W(TW)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_win_en(cfg_win_en),
      .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
      .io_rdata(io_rdata), .io_hit(io_hit), .tick(tick), .evt_pwrbtn(evt_pwrbtn),
      .evt_rtc(evt_rtc), .evt_gbl(evt_gbl), .sci(sci)
   );

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic io_write(logic [15:0] a, logic [15:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic io_read(logic [15:0] a, output logic [31:0] d, output logic h);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #1;
      d = io_rdata; h = io_hit;
      io_rd = 1'b0;
   endtask

   task automatic rd_chk(string req, string what, logic [15:0] a, logic [31:0] exp);
      logic [31:0] d; logic h;
      io_read(a, d, h);
      chk(req, what, d, exp);
   endtask

   task automatic run_ticks(int n);
      if (n > 0) begin
         @(negedge clk); tick = 1'b1;
         repeat (n) @(negedge clk);
         tick = 1'b0;
      end
   endtask

   task automatic t_reset();
      cfg_win_en = 1'b1;
      rd_chk("R1", "status", BASE + 16'h00, 0);
      rd_chk("R1", "enable", BASE + 16'h02, 0);
      rd_chk("R1", "control", BASE + 16'h04, 0);
      rd_chk("R1", "timer", BASE + 16'h08, 0);
      chk("R1", "sci", {31'b0, sci}, 0);
      cfg_win_en = 1'b0;
   endtask

   task automatic t_window();
      logic [31:0] d; logic h;
      io_read(BASE + 16'h02, d, h);
      chk("R2", "hit while disabled", {31'b0, h}, 0);
      chk("R3", "rdata unclaimed", d, 0);
      io_write(BASE + 16'h02, 16'h0100);
      cfg_win_en = 1'b1;
      rd_chk("R9", "enable after disabled write", BASE + 16'h02, 0);
      io_write(BASE + 16'h0042, 16'h0100);
      rd_chk("R9", "enable after outside write", BASE + 16'h02, 0);
      io_read(BASE + 16'h3F, d, h);
      chk("R2", "hit at last byte", {31'b0, h}, 1);
      io_read(BASE + 16'h40, d, h);
      chk("R2", "hit past end", {31'b0, h}, 0);
      io_read(BASE - 16'h1, d, h);
      chk("R2", "hit before base", {31'b0, h}, 0);
      @(negedge clk); io_addr = BASE; #1;
      chk("R2", "hit without strobe", {31'b0, io_hit}, 0);
      cfg_base = 32'h1234_C07F;
      io_read(16'hC042, d, h);
      chk("R2", "hit after relocation", {31'b0, h}, 1);
      io_read(BASE + 16'h02, d, h);
      chk("R2", "old base after relocation", {31'b0, h}, 0);
      cfg_base = 32'hABCD_B02A;
   endtask

   task automatic t_regs();
      io_write(BASE + 16'h02, 16'hFFFF);
      rd_chk("R3", "enable rw", BASE + 16'h02, 32'h0000_FFFF);
      io_write(BASE + 16'h04, 16'h2C01);
      rd_chk("R3", "control rw", BASE + 16'h04, 32'h0000_2C01);
      io_write(BASE + 16'h08, 16'h0155);
      rd_chk("R7", "timer write ignored", BASE + 16'h08, 0);
      io_write(BASE + 16'h0C, 16'h1234);
      rd_chk("R3", "unmapped offset", BASE + 16'h0C, 0);
      chk("R6", "sci with no status", {31'b0, sci}, 0);
      io_write(BASE + 16'h02, 16'h0000);
   endtask

   task automatic t_events();
      @(negedge clk); evt_pwrbtn = 1'b1;
      rd_chk("R5", "power button sets bit 8", BASE, 32'h0100);
      chk("R6", "sci without enable", {31'b0, sci}, 0);
      io_write(BASE + 16'h02, 16'h0100);
      #1 chk("R6", "sci enabled power button", {31'b0, sci}, 1);
      io_write(BASE, 16'h0000);
      rd_chk("R4", "write zero keeps status", BASE, 32'h0100);
      io_write(BASE, 16'h0100);
      rd_chk("R5", "held level no re-set", BASE, 0);
      #1 chk("R6", "sci after clear", {31'b0, sci}, 0);
      @(negedge clk); evt_pwrbtn = 1'b0; evt_rtc = 1'b1;
      @(negedge clk); evt_gbl = 1'b1;
      rd_chk("R5", "rtc and global lock", BASE, 32'h0420);
      io_write(BASE + 16'h02, 16'hFADE);
      #1 chk("R6", "non-source enables ignored", {31'b0, sci}, 0);
      io_write(BASE + 16'h02, 16'h0020);
      #1 chk("R6", "global lock enable", {31'b0, sci}, 1);
      io_write(BASE, 16'hFFFF);
      rd_chk("R4", "clear all", BASE, 0);
      @(negedge clk); evt_rtc = 1'b0; evt_gbl = 1'b0;
      io_write(BASE + 16'h02, 16'h0000);
   endtask

   task automatic t_collide();
      @(negedge clk);
      io_addr = BASE; io_wdata = 16'h0400; io_wr = 1'b1; evt_rtc = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
      rd_chk("R10", "set wins over clear", BASE, 32'h0400);
      io_write(BASE, 16'h0400);
      evt_rtc = 1'b0;
      rd_chk("R10", "cleared afterwards", BASE, 0);
   endtask

   task automatic t_timer();
      logic [31:0] t0, t1; logic h;
      io_read(BASE + 16'h08, t0, h);
      run_ticks(37);
      io_read(BASE + 16'h08, t1, h);
      chk("R7", "timer after 37 ticks", t1, (t0 + 37) % (1 << TW));
      repeat (5) @(negedge clk);
      rd_chk("R7", "timer holds without tick", BASE + 16'h08, t1);
   endtask

   task automatic t_overflow();
      logic [31:0] t; logic h; int k;
      localparam int HALF = 1 << (TW - 1);
      io_write(BASE + 16'h02, 16'h0001);
      io_write(BASE, 16'h0001);
      io_read(BASE + 16'h08, t, h);
      k = HALF - int'(t % HALF);
      run_ticks(k - 1);
      rd_chk("R8", "before top-bit change", BASE, 0);
      run_ticks(1);
      rd_chk("R8", "top bit change sets bit 0", BASE, 32'h0001);
      #1 chk("R6", "timer sci", {31'b0, sci}, 1);
      io_write(BASE, 16'h0001);
      run_ticks(HALF - 1);
      rd_chk("R8", "before second change", BASE, 0);
      run_ticks(1);
      rd_chk("R8", "second change sets bit 0", BASE, 32'h0001);
      io_write(BASE + 16'h02, 16'h0000);
      io_write(BASE, 16'h0001);
      run_ticks(HALF);
      rd_chk("R8", "disabled change lost", BASE, 0);
      io_write(BASE + 16'h02, 16'h0001);
      #1 chk("R8", "no late sci", {31'b0, sci}, 0);
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_window();
      t_regs();
      t_events();
      t_collide();
      t_timer();
      t_overflow();
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         finish_run();
      end
   end
endmodule